// File: doc/BRIEF.md
# PCM Frame-Sync Serial Port

This block is the 8-bit serial side of one codec channel. On the transmit side it drives a data pin, with an enable for an external tri-state buffer. The pin carries a code word taken from the companding encoder, framed by a transmit sync and a transmit bit clock. On the receive side it collects 8 serial bits under a receive sync and a receive bit clock. It hands them on as a parallel word together with a one-cycle valid strobe. The encoder and decoder themselves sit outside the block.

All pins are sampled on a faster system clock, and the bit-clock and sync edges are found by comparing each sample with the previous one. The width of each transmit sync pulse, counted in falling bit-clock edges, selects one of two sync formats:

- **Narrow format:** a pulse covering one falling edge. This is the format after reset.
- **Wide format:** a pulse covering three or more falling edges.

In the wide format, the output is switched on by the later of the sync rising and a rising bit-clock edge. It is switched off by the later of the sync falling and the falling edge that ends the last bit.

The transmit sequencer has five states:

- **TX_IDLE:** waiting for a frame.
- **TX_ARM:** the frame has started and the block waits for a rising bit-clock edge.
- **TX_SHIFT:** the output is on and bits are being shifted.
- **TX_HOLD:** wide format only. The last bit is done but the sync is still high, so the output stays on.
- **TX_WAIT:** the output is off and the block waits for the sync to drop.

Its transitions are:

- **start-narrow:** TX_IDLE to TX_ARM, on a falling edge with the sync high, in the narrow format.
- **start-wide-late-sync:** TX_IDLE to TX_SHIFT, on a sync rise while the bit clock is high.
- **start-wide-early-sync:** TX_IDLE to TX_ARM, on a sync rise while the bit clock is low.
- **arm-enable:** TX_ARM to TX_SHIFT, on a rising edge.
- **end-bits:** from TX_SHIFT, on the falling edge after the 8th bit. It goes to TX_HOLD (wide format, sync high), to TX_WAIT (narrow format, sync high) or to TX_IDLE.
- **hold-release:** TX_HOLD to TX_IDLE, on the sync falling.
- **wait-release:** TX_WAIT to TX_IDLE, once the sync is low.

The receive sequencer has three states:

- **RX_IDLE:** waiting for a frame.
- **RX_CAP:** taking in bits.
- **RX_WAIT:** waiting for the sync to drop before it can start again.

Its transitions are:

- **rx-start:** RX_IDLE to RX_CAP, on a falling edge with the sync high.
- **rx-done:** from RX_CAP, on the 8th capture. It goes to RX_WAIT if the sync is still high, otherwise to RX_IDLE.
- **rx-release:** RX_WAIT to RX_IDLE, on the sync falling.

Top module: `pcm_sync_port`

## Requirements
- R1: After reset, tx_doe is 0, long_fmt is 0 (narrow format) and rx_valid is 0.
- R2: When tx_fsync falls, the pulse width is judged by the number of falling tx_bclk edges seen with tx_fsync high. A width of 1 sets long_fmt to 0, and a width of 3 or more sets it to 1. A width of 2 (or 0) leaves long_fmt unchanged. long_fmt changes at no other time.
- R3: In the narrow format, a falling tx_bclk edge with tx_fsync high starts a frame. tx_doe goes high at the next rising edge, and tx_dout then shows bit 7 of the frame's word.
- R4: While enabled, tx_dout presents the word MSB first, moving on one bit at each rising tx_bclk edge, and holds steady between rising edges.
- R5: In the narrow format, tx_doe returns to 0 on the falling tx_bclk edge that follows the rising edge which presented bit 0, whatever tx_fsync does.
- R6: In the wide format, the rise of tx_fsync starts a frame. tx_doe goes high at that rise if tx_bclk is already high; otherwise it goes high at the next rising edge. Bit 7 comes first in both cases.
- R7: In the wide format, tx_doe goes low at the falling edge after bit 0, or at the fall of tx_fsync if that comes later. Until then tx_dout holds bit 0.
- R8: Each frame start captures tx_code. The word sent in a frame is the one captured at the previous frame start, so the first frame after reset sends 0x00.
- R9: A falling rx_bclk edge with rx_fsync high starts capture. rx_din is taken on each of the next 8 falling edges, MSB first. rx_valid is then high for exactly one cycle with the word on rx_word.
- R10: After a capture, no new capture starts until rx_fsync has gone low, so a sync held high through the word yields a single rx_valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_code | input | WORD_W | Code word from the encoder |
| tx_dout | output | 1 | Serial transmit data |
| tx_doe | output | 1 | Enable for the external tri-state buffer on tx_dout |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_din | input | 1 | Serial receive data |
| rx_word | output | WORD_W | Last word received |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_word |
| long_fmt | output | 1 | 1 when the wide sync format is in use |

## Verification
The assertions assume three things about the inputs. A bit-clock edge and a sync edge never land in the same system-clock sample. Each bit-clock half period spans several system clocks. A sync pulse always starts in a frame the block is ready to take. The bench keeps to these rules in three ways:

- It changes the bit clock only at the start of each eight-cycle half period.
- It moves the syncs only in the middle of a half period.
- It changes the serial data one cycle later still, and leaves idle half periods between frames.

The expected enable windows, bit positions and format are worked out from the half-period index at which each sync rises and falls.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_ARM,
        TX_SHIFT,
        TX_HOLD,
        TX_WAIT
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_CAP,
        RX_WAIT
    } rx_state_e;

endpackage

// File: rtl/pcm_edge_sample.sv
module pcm_edge_sample #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] cur,
    output logic [N-1:0] prv
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur[i] <= 1'b0;
                prv[i] <= 1'b0;
            end else begin
                cur[i] <= d[i];
                prv[i] <= cur[i];
            end
        end
    end
endmodule

// File: rtl/pcm_fmt_detect.sv
module pcm_fmt_detect #(
    parameter int LONG_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic b_cur,
    input  logic b_prv,
    input  logic f_cur,
    input  logic f_prv,
    output logic long_fmt
);
    localparam int CW = $clog2(LONG_MIN + 1);
    localparam logic [CW-1:0] SAT = CW'(LONG_MIN);

    logic          b_fall, f_rise, f_fall;
    logic [CW-1:0] width;

    assign b_fall = b_prv & ~b_cur;
    assign f_rise = f_cur & ~f_prv;
    assign f_fall = f_prv & ~f_cur;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width    <= '0;
            long_fmt <= 1'b0;
        end else begin
            if (f_rise)
                width <= '0;
            else if (b_fall && f_cur && width != SAT)
                width <= width + CW'(1);
            if (f_fall) begin
                if (width == CW'(1))
                    long_fmt <= 1'b0;
                else if (width == SAT)
                    long_fmt <= 1'b1;
            end
        end
    end

    // R2: the format only moves when a sync pulse ends
    assert_fmt_on_sync_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(long_fmt) |-> $past(f_fall));
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              b_cur,
    input  logic              b_prv,
    input  logic              f_cur,
    input  logic              f_prv,
    input  logic              long_fmt,
    input  logic [WORD_W-1:0] code,
    output logic              dout,
    output logic              doe
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W);

    tx_state_e         state, nxt;
    logic [WORD_W-1:0] sr, pend;
    logic [CNT_W-1:0]  cnt;
    logic              b_rise, b_fall, f_rise, f_fall, load, step;

    assign b_rise = b_cur & ~b_prv;
    assign b_fall = b_prv & ~b_cur;
    assign f_rise = f_cur & ~f_prv;
    assign f_fall = f_prv & ~f_cur;

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE: begin
                if (long_fmt) begin
                    if (f_rise) nxt = b_cur ? TX_SHIFT : TX_ARM;
                end else if (b_fall && f_cur) begin
                    nxt = TX_ARM;
                end
            end
            TX_ARM:   if (b_rise) nxt = TX_SHIFT;
            TX_SHIFT: if (b_fall && cnt == LAST)
                          nxt = !f_cur ? TX_IDLE : (long_fmt ? TX_HOLD : TX_WAIT);
            TX_HOLD:  if (f_fall) nxt = TX_IDLE;
            TX_WAIT:  if (!f_cur) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    assign load = (state == TX_IDLE) && (nxt != TX_IDLE);
    assign step = (state == TX_SHIFT) && b_rise && (cnt != LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '0;
            pend <= '0;
            cnt  <= '0;
        end else begin
            if (load) begin
                sr   <= pend;
                pend <= code;
            end else if (step) begin
                sr <= {sr[WORD_W-2:0], 1'b0};
            end
            if (state != TX_SHIFT && nxt == TX_SHIFT)
                cnt <= CNT_W'(1);
            else if (step)
                cnt <= cnt + CNT_W'(1);
        end
    end

    always_comb begin
        doe  = (state == TX_SHIFT) || (state == TX_HOLD);
        dout = doe & sr[WORD_W-1];
    end

    // R3 R6: enable appears only after a rising bit clock or a sync rise
    assert_oe_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(doe) |-> $past(b_rise || f_rise));
    // R5 R7: enable drops only after a falling bit clock or a sync fall
    assert_oe_off_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(doe) |-> $past(b_fall || f_fall));
    // R4: the driven bit moves only on a rising bit clock
    assert_bit_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (doe && $past(doe) && !$past(b_rise)) |-> $stable(dout));
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              b_cur,
    input  logic              b_prv,
    input  logic              f_cur,
    input  logic              f_prv,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic              valid
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    rx_state_e         state, nxt;
    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    logic              din_q, b_fall, f_fall, take;

    assign b_fall = b_prv & ~b_cur;
    assign f_fall = f_prv & ~f_cur;
    assign take   = (state == RX_CAP) && b_fall;

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE: if (b_fall && f_cur) nxt = RX_CAP;
            RX_CAP:  if (b_fall && cnt == LAST) nxt = f_cur ? RX_WAIT : RX_IDLE;
            RX_WAIT: if (f_fall) nxt = RX_IDLE;
            default: nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= 1'b0;
            sr    <= '0;
            cnt   <= '0;
            word  <= '0;
            valid <= 1'b0;
        end else begin
            din_q <= din;
            valid <= take && (cnt == LAST);
            if (state == RX_IDLE) cnt <= '0;
            else if (take)        cnt <= cnt + CNT_W'(1);
            if (take) sr <= {sr[WORD_W-2:0], din_q};
            if (take && cnt == LAST) word <= {sr[WORD_W-2:0], din_q};
        end
    end

    // R9: the strobe lasts a single cycle
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R9: the strobe follows a falling bit clock
    assert_valid_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(b_fall));
endmodule

// File: rtl/pcm_sync_port.sv
module pcm_sync_port #(
    parameter int WORD_W   = 8,
    parameter int LONG_MIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_bclk,
    input  logic              tx_fsync,
    input  logic [WORD_W-1:0] tx_code,
    output logic              tx_dout,
    output logic              tx_doe,
    input  logic              rx_bclk,
    input  logic              rx_fsync,
    input  logic              rx_din,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              long_fmt
);
    logic [1:0] tx_cur, tx_prv, rx_cur, rx_prv;

    pcm_edge_sample #(.N(2)) u_tx_edges (
        .clk(clk), .rst_n(rst_n), .d({tx_fsync, tx_bclk}), .cur(tx_cur), .prv(tx_prv)
    );

    pcm_edge_sample #(.N(2)) u_rx_edges (
        .clk(clk), .rst_n(rst_n), .d({rx_fsync, rx_bclk}), .cur(rx_cur), .prv(rx_prv)
    );

    pcm_fmt_detect #(.LONG_MIN(LONG_MIN)) u_fmt (
        .clk(clk), .rst_n(rst_n),
        .b_cur(tx_cur[0]), .b_prv(tx_prv[0]), .f_cur(tx_cur[1]), .f_prv(tx_prv[1]),
        .long_fmt(long_fmt)
    );

    pcm_tx #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .b_cur(tx_cur[0]), .b_prv(tx_prv[0]), .f_cur(tx_cur[1]), .f_prv(tx_prv[1]),
        .long_fmt(long_fmt), .code(tx_code), .dout(tx_dout), .doe(tx_doe)
    );

    pcm_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .b_cur(rx_cur[0]), .b_prv(rx_prv[0]), .f_cur(rx_cur[1]), .f_prv(rx_prv[1]),
        .din(rx_din), .word(rx_word), .valid(rx_valid)
    );

    // R1: a quiet port after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!tx_doe && !rx_valid && !long_fmt));
endmodule

// File: tb/tb_pcm_sync_port.sv
module tb_pcm_sync_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0, fs = 1'b0, dr = 1'b0;
    logic [7:0] tx_code = 8'h00;
    logic       tx_dout, tx_doe, rx_valid, long_fmt;
    logic [7:0] rx_word;

    int   errors = 0, checks = 0, vcnt = 0, frame_no = 0;
    logic [7:0] last_word = 8'h00;
    logic [7:0] pend_exp = 8'h00;
    bit   mode_exp = 1'b0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    pcm_sync_port dut (
        .clk(clk), .rst_n(rst_n),
        .tx_bclk(bclk), .tx_fsync(fs), .tx_code(tx_code),
        .tx_dout(tx_dout), .tx_doe(tx_doe),
        .rx_bclk(bclk), .rx_fsync(fs), .rx_din(dr),
        .rx_word(rx_word), .rx_valid(rx_valid), .long_fmt(long_fmt)
    );

    always @(posedge clk) if (rst_n && rx_valid) begin
        vcnt      <= vcnt + 1;
        last_word <= rx_word;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s frame %0d: actual=%0h expected=%0h", req, frame_no, act, exp);
        end
    endtask

    // one frame; hr/hf = half-period indices of the sync rise/fall
    task automatic frame(input int hr, input int hf, input logic [7:0] code, input logic [7:0] rxv);
        int t, e, n, falls, v0;
        bit lm, nm;
        logic [7:0] outv;
        lm = mode_exp;
        outv = pend_exp;
        pend_exp = code;
        tx_code = code;
        t = (hr % 2 == 0) ? hr + 1 : hr + 2;
        e = lm ? ((hr % 2 == 0) ? hr : hr + 1) : t + 1;
        falls = 0;
        for (int h = hr + 1; h <= hf; h++) if (h % 2 == 1) falls++;
        nm = (falls == 1) ? 1'b0 : (falls >= 3) ? 1'b1 : lm;
        n = hf + 3;
        if (t + 18 > n) n = t + 18;
        if (e + 17 > n) n = e + 17;
        if (n % 2 == 1) n++;
        v0 = vcnt;
        for (int h = 0; h < n; h++) begin
            bit oe_x;
            int k;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (c == 0) bclk = (h % 2 == 0);
                if (c == 3 && h == hr) fs = 1'b1;
                if (c == 3 && h == hf) fs = 1'b0;
                if (c == 4 && h % 2 == 0 && h >= t + 1 && h <= t + 15)
                    dr = rxv[7 - (h - t - 1) / 2];
            end
            // R2: format before and after the end of the pulse
            chk(long_fmt == ((h >= hf) ? nm : lm), "R2", long_fmt, (h >= hf) ? nm : lm);
            oe_x = (h >= e && h <= e + 14) || (lm && h > e + 14 && h < hf);
            if (h == e)
                chk(tx_doe == oe_x, lm ? "R6" : "R3", tx_doe, oe_x);
            else
                chk(tx_doe == oe_x, lm ? "R7" : "R5", tx_doe, oe_x);
            if (oe_x) begin
                k = (h - e) / 2;
                if (k > 7) k = 7;
                chk(tx_dout == outv[7 - k], (frame_no == 0) ? "R8" : "R4", tx_dout, outv[7 - k]);
            end
            if (h == t + 16) begin
                chk(vcnt == v0 + 1, "R9", vcnt - v0, 1);
                chk(last_word == rxv, "R9", last_word, rxv);
            end
        end
        // R10: one capture per sync pulse, even with the sync held
        chk(vcnt == v0 + 1, "R10", vcnt - v0, 1);
        mode_exp = nm;
        frame_no++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_doe == 1'b0, "R1", tx_doe, 0);
        chk(long_fmt == 1'b0, "R1", long_fmt, 0);
        chk(rx_valid == 1'b0, "R1", rx_valid, 0);

        // narrow format sweep over every code, sync rising in either half
        for (int i = 0; i < 256; i++) begin
            int hr;
            hr = i % 2;
            frame(hr, hr + 2, 8'(i), 8'(i) ^ 8'hA5);
        end
        // R2: width-2 pulse keeps the narrow format
        frame(0, 4, 8'h3C, 8'hC3);
        frame(0, 2, 8'h81, 8'h18);
        // R2: width-3 pulse switches to the wide format
        frame(0, 6, 8'h5A, 8'h66);
        // wide format: both enable orderings, several widths, held syncs
        for (int i = 0; i < 48; i++) begin
            int hr, hf;
            hr = i % 4;
            hf = (i % 8 == 7) ? hr + 22 + (i % 2) : hr + 6 + (i % 3);
            frame(hr, hf, 8'(i * 37 + 11), 8'(i * 53 + 7));
        end
        // R2: width-2 pulse keeps the wide format
        frame(0, 4, 8'hF0, 8'h0F);
        frame(1, 5, 8'h96, 8'h69);
        // R2: width-1 pulse returns to the narrow format
        frame(0, 2, 8'hC5, 8'h5C);
        frame(0, 2, 8'h27, 8'h72);
        frame(1, 3, 8'hE1, 8'h1E);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule